// File: doc/BRIEF.md
# Byte Stream Feeder and Digest Serialiser

This block sits between a host that sends bytes one at a time and a block-hashing sequencer that takes bytes under its own ready signal. On the input side, a two-entry skid buffer takes host bytes and passes them downstream whenever the sequencer can take them. Short downstream stalls therefore never lose a byte. Each byte carries its end-of-message flag through the buffer. The first byte sent downstream after an idle period is tagged as the start of a message.

After the final byte has gone downstream, the block waits for the sequencer to report that the whole message is finished. It then captures the 256-bit result and sends it to the host as 32 bytes, one per cycle, starting with the most significant byte. The block does no hashing itself.

Top module: `hash_byte_shell`

## Requirements
- R1: After reset, `ready` is 1 and `busy`, `out_valid` and `ds_valid` are 0.
- R2: Every byte accepted from the host (`in_valid` and `ready` both high at a clock edge) goes downstream exactly once and in arrival order, for any pattern of `ds_ready`. `ds_valid` is high exactly when at least one accepted byte has not yet been taken downstream.
- R3: The buffer holds at most two bytes. `ready` is low while it holds two bytes, and an `in_valid` strobe while `ready` is low is ignored.
- R4: While `ds_valid` is high and `ds_ready` is low, `ds_valid`, `ds_byte` and `ds_last` hold their values into the next cycle.
- R5: `ds_first` is high on the first byte sent downstream for a message and low on every later byte of that message.
- R6: `ds_last` is high only on the byte that was accepted with `in_last`. Once that byte is accepted, `ready` stays low until the digest dump has finished.
- R7: No digest byte is sent until all bytes have gone downstream and `ds_done` is sampled high after that. A `ds_done` that arrives while bytes are still being fed is ignored.
- R8: The cycle after `ds_done` is accepted, `out_valid` goes high for exactly 32 consecutive cycles. Byte k (k = 0..31) is `ds_digest[255-8k -: 8]` as captured when `ds_done` was accepted.
- R9: `busy` goes high the cycle after the first byte of a message is accepted. It stays high through the last digest byte and is low the next cycle, when `ready` is 1 again.
- R10: `out_byte` is 0 whenever `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_byte | input | 8 | Host data byte |
| in_valid | input | 1 | Host byte strobe |
| in_last | input | 1 | Marks the final byte of a message |
| ready | output | 1 | A host byte can be accepted this cycle |
| busy | output | 1 | A message is in progress |
| out_byte | output | 8 | Digest byte to the host |
| out_valid | output | 1 | Digest byte strobe |
| ds_byte | output | 8 | Byte to the sequencer |
| ds_valid | output | 1 | `ds_byte` is valid |
| ds_first | output | 1 | First byte of a message |
| ds_last | output | 1 | Last byte of a message |
| ds_ready | input | 1 | Sequencer takes the byte this cycle |
| ds_done | input | 1 | Sequencer has finished the message |
| ds_digest | input | 256 | Result of the finished message |

## Verification
A wrong buffer count shows up as a wrong `ready` or `ds_valid` level within one cycle of the bad update. A wrong slot shift shows up as a byte dropped, repeated or out of order at the next downstream handshake. A stuck or early state shows up as a digest strobe outside its window, or as `busy` and `ready` levels that do not match the count of accepted and delivered bytes in that same cycle. The bench sweeps message lengths, downstream stall patterns, host gaps, strobes while `ready` is low and early `ds_done` pulses, and compares every port every cycle against a model kept from byte counts alone.

// File: rtl/hash_byte_shell.sv
module hash_byte_shell #(
  parameter int W  = 8,
  parameter int NB = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    in_byte,
  input  logic            in_valid,
  input  logic            in_last,
  output logic            ready,
  output logic            busy,
  output logic [W-1:0]    out_byte,
  output logic            out_valid,
  output logic [W-1:0]    ds_byte,
  output logic            ds_valid,
  output logic            ds_first,
  output logic            ds_last,
  input  logic            ds_ready,
  input  logic            ds_done,
  input  logic [W*NB-1:0] ds_digest
);
  localparam int DW = W * NB;
  localparam int CW = $clog2(NB);

  typedef enum logic [1:0] {IDLE, FEED, WAIT, DUMP} st_t;

  st_t            st;
  logic [W-1:0]   s0, s1;
  logic           l0, l1;
  logic [1:0]     cnt;
  logic           got_last, first_pend;
  logic [DW-1:0]  sreg;
  logic [CW-1:0]  idx;
  logic           push, pop;

  assign ready     = (st == IDLE || (st == FEED && !got_last)) && cnt != 2'd2;
  assign ds_valid  = (st == FEED) && cnt != 2'd0;
  assign ds_byte   = s0;
  assign ds_last   = ds_valid && l0;
  assign ds_first  = ds_valid && first_pend;
  assign out_valid = (st == DUMP);
  assign out_byte  = out_valid ? sreg[DW-1 -: W] : '0;
  assign busy      = (st != IDLE);
  assign push      = in_valid && ready;
  assign pop       = ds_valid && ds_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      s0  <= '0;
      s1  <= '0;
      l0  <= 1'b0;
      l1  <= 1'b0;
    end else begin
      case ({push, pop})
        2'b10: begin
          if (cnt == 2'd0) begin
            s0 <= in_byte;
            l0 <= in_last;
          end else begin
            s1 <= in_byte;
            l1 <= in_last;
          end
          cnt <= cnt + 2'd1;
        end
        2'b01: begin
          s0  <= s1;
          l0  <= l1;
          cnt <= cnt - 2'd1;
        end
        2'b11: begin
          if (cnt == 2'd1) begin
            s0 <= in_byte;
            l0 <= in_last;
          end else begin
            s0 <= s1;
            l0 <= l1;
            s1 <= in_byte;
            l1 <= in_last;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= IDLE;
      got_last   <= 1'b0;
      first_pend <= 1'b0;
      sreg       <= '0;
      idx        <= '0;
    end else begin
      case (st)
        IDLE: if (push) begin
          st         <= FEED;
          first_pend <= 1'b1;
          got_last   <= in_last;
        end
        FEED: begin
          if (push && in_last) got_last <= 1'b1;
          if (pop) first_pend <= 1'b0;
          if (pop && l0) st <= WAIT;
        end
        WAIT: if (ds_done) begin
          sreg <= ds_digest;
          idx  <= '0;
          st   <= DUMP;
        end
        default: begin
          sreg <= sreg << W;
          idx  <= idx + 1'b1;
          if (idx == CW'(NB - 1)) begin
            st       <= IDLE;
            got_last <= 1'b0;
          end
        end
      endcase
    end
  end
endmodule

module hash_byte_shell_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         ready,
  input logic         busy,
  input logic [W-1:0] out_byte,
  input logic         out_valid,
  input logic [W-1:0] ds_byte,
  input logic         ds_valid,
  input logic         ds_first,
  input logic         ds_last,
  input logic         ds_ready,
  input logic [1:0]   cnt
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt <= 2'd2);                                                     // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    ds_valid && !ds_ready |=> ds_valid && $stable(ds_byte) && $stable(ds_last)); // R4
  AST_FIRST_ONCE: assert property (@(posedge clk) disable iff (rst)
    ds_valid && ds_ready && ds_first |=> !ds_first);                  // R5
  AST_NO_ACCEPT_IN_DUMP: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !ready);                                            // R6
  AST_DUMP_CONTIG: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |=> out_valid);                                  // R8
  AST_BUSY_ENDS_AFTER_DUMP: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(out_valid));                                // R9
  AST_QUIET_OUT: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> out_byte == '0);                                   // R10
endmodule

bind hash_byte_shell hash_byte_shell_chk #(.W(W)) chk (
  .clk(clk), .rst(rst), .ready(ready), .busy(busy),
  .out_byte(out_byte), .out_valid(out_valid),
  .ds_byte(ds_byte), .ds_valid(ds_valid), .ds_first(ds_first),
  .ds_last(ds_last), .ds_ready(ds_ready), .cnt(cnt)
);

// File: tb/hash_byte_shell_test.sv
module hash_byte_shell_test;
  localparam int NB = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [7:0]   in_byte = '0;
  logic         in_valid = 1'b0, in_last = 1'b0;
  logic         ready, busy, out_valid, ds_valid, ds_first, ds_last;
  logic [7:0]   out_byte, ds_byte;
  logic         ds_ready = 1'b0, ds_done = 1'b0;
  logic [255:0] ds_digest = '0;

  hash_byte_shell uut (
    .clk(clk), .rst(rst), .in_byte(in_byte), .in_valid(in_valid), .in_last(in_last),
    .ready(ready), .busy(busy), .out_byte(out_byte), .out_valid(out_valid),
    .ds_byte(ds_byte), .ds_valid(ds_valid), .ds_first(ds_first), .ds_last(ds_last),
    .ds_ready(ds_ready), .ds_done(ds_done), .ds_digest(ds_digest)
  );

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  int acc = 0, pop = 0, lastpop = 0, dumpleft = 0, k = 0, msg_len = 0, seed = 0;
  int sm = 0, cyc = 0;
  bit lastacc = 0, busy_exp = 0, msg_done = 0, mon_on = 0;
  logic [7:0] sent [0:63];

  function automatic logic [7:0] dig_byte(int s, int j);
    return 8'((s * 29 + j * 11 + 5) & 255);
  endfunction

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", r, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (mon_on) begin
    automatic bit waiting = lastacc && (pop == acc) && dumpleft == 0 && !msg_done;
    automatic bit exp_rdy = !lastacc && (acc - pop) < 2;
    automatic bit set_busy = 0;
    chk(ready == exp_rdy, "R3/R6 ready", ready, exp_rdy);
    chk(ds_valid == (acc != pop), "R2 ds_valid", ds_valid, acc != pop);
    chk(busy == busy_exp, "R9 busy", busy, busy_exp);
    if (dumpleft > 0) chk(out_valid == 1'b1, "R8 out_valid", out_valid, 1);
    else              chk(out_valid == 1'b0, "R7 out_valid", out_valid, 0);
    if (!out_valid) chk(out_byte == 8'h00, "R10 out_byte", out_byte, 0);
    if (in_valid && ready) begin
      acc++;
      if (in_last) lastacc = 1;
      if (!busy_exp) set_busy = 1;
    end
    if (ds_valid && ds_ready) begin
      chk(ds_byte == sent[pop], "R2 ds_byte", ds_byte, sent[pop]);
      chk(ds_first == (pop == 0), "R5 ds_first", ds_first, pop == 0);
      chk(ds_last == (pop == msg_len - 1), "R6 ds_last", ds_last, pop == msg_len - 1);
      pop++;
    end
    if (out_valid && dumpleft > 0) begin
      chk(out_byte == dig_byte(seed, k), "R8 out_byte", out_byte, dig_byte(seed, k));
      k++;
      dumpleft--;
      if (dumpleft == 0) begin
        lastacc = 0; busy_exp = 0; msg_done = 1;
        lastpop = pop; acc = 0; pop = 0;
      end
    end
    if (waiting && ds_done) dumpleft = NB;
    if (set_busy) busy_exp = 1;
  end

  initial forever begin
    @(posedge clk); #2;
    cyc++;
    case (sm)
      0: ds_ready = 1'b1;
      1: ds_ready = (cyc % 3) != 0;
      2: ds_ready = (cyc % 7) < 2;
      default: ds_ready = (cyc % 2) == 0;
    endcase
  end

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  task automatic run(int len, int smode, int hm, int dly);
    logic [255:0] d;
    seed++;
    msg_len = len; msg_done = 0; k = 0; sm = smode;
    for (int i = 0; i < len; i++) sent[i] = 8'((seed * 17 + i * 37 + 3) & 255);
    for (int j = 0; j < NB; j++) d[255 - 8*j -: 8] = dig_byte(seed, j);
    ds_digest = d;
    fork
      begin
        int i = 0;
        while (i < len) begin
          @(posedge clk); #2;
          if (ready) begin
            in_valid = 1; in_byte = sent[i]; in_last = (i == len - 1); i++;
            if (hm % 2 == 1) begin
              @(posedge clk); #2; in_valid = 0; in_last = 0;
            end
          end else if ((hm / 2) % 2 == 1) begin
            in_valid = 1; in_byte = 8'hEE; in_last = 1;   // R3 strobe while not ready
          end else begin
            in_valid = 0; in_last = 0;
          end
        end
        @(posedge clk); #2; in_valid = 0; in_last = 0;
      end
      begin
        if (hm == 3 && len >= 4) begin                     // R7 early done
          wait (pop >= 1);
          @(posedge clk); #2; ds_done = 1;
          @(posedge clk); #2; ds_done = 0;
        end
      end
    join
    wait (lastacc && pop == acc);
    repeat (dly) @(posedge clk);
    @(posedge clk); #2; ds_done = 1;
    @(posedge clk); #2; ds_done = 0;
    wait (msg_done);
    @(negedge clk);
    chk(lastpop == len, "R2 delivered count", lastpop, len);
    chk(k == NB, "R8 digest count", k, NB);
    chk(ready == 1'b1 && busy == 1'b0, "R9 idle after dump", {ready, busy}, 2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 0;
    @(negedge clk);
    chk(ready == 1'b1, "R1 ready", ready, 1);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(ds_valid == 1'b0, "R1 ds_valid", ds_valid, 0);
    mon_on = 1;
    for (int len = 1; len <= 12; len++)
      for (int s = 0; s < 4; s++)
        for (int h = 0; h < 4; h++)
          run(len, s, h, (len + h) % 4);
    summary();
    $finish;
  end
endmodule